// File: doc/BRIEF.md
# Boot-Block Flash Program/Erase Sequencer

This block is the internal automation of a 16-bit boot-block flash array. A host issues commands over an SRAM-like bus, and the block runs word programs and block erases against a small behavioural cell array. An erase can be paused so the host can read, or program words in, other blocks. A word program can be paused so the host can read. A ready/busy output and an 8-bit status register report progress and errors.

The array has twenty-three erase blocks: two boot blocks, six parameter blocks and fifteen main blocks. A parameter picks whether the small blocks sit at the bottom or the top of the address space. Block sizes are scaled-down powers of two so that the array stays small.

A write-protect input locks the boot blocks. A high-voltage override input unlocks every block. Parameter blocks can never be locked. Two digital flags stand in for supply levels: one for the program supply and one for the reset/deep power-down pin. Each operation lasts for a cycle count that depends on the class of the target block.

Top module: `flash_seq`

## Requirements
- R1: With the default orientation, blocks 0-1 (boot) and 2-7 (parameter) each span SMALL_W words starting at address 0. Blocks 8-22 (main) each span LARGE_W words after them. An erase (0x20 then 0xD0 at any address in the block) sets every word of that block, and no other word, to 0xFFFF.
- R2: A word program (0x40, then a data write) makes the target word equal to its old value AND the written data. Read-array mode (0xFF) returns the word at `addr` on `rdata`. After reset the array reads 0xFFFF and the block is in read-array mode.
- R3: Address and data of a bus write are taken at the rising edge of `we_n`. Values present earlier in the low phase have no effect.
- R4: While `wp_n` is low and `unlock_all` is low, a program or erase aimed at a boot block is refused. It sets status bit 1 (locked) plus bit 4 (program) or bit 5 (erase), and leaves the array unchanged. Parameter blocks still accept programs.
- R5: While `unlock_all` is high, boot blocks accept programs regardless of `wp_n`.
- R6: While `pwrdn_n` is low, an operation in progress is aborted without changing the array, `ready` is high, `rdata` is 0 and bus writes are ignored. After release the block is in read-array mode with all status errors clear.
- R7: `ready` is low only while a program or erase runs. It is high when idle, when an operation is suspended, and in power-down. Status bit 7 mirrors it.
- R8: Busy time in cycles is T_PROG_SMALL or T_PROG_LARGE for a program, and T_ERS_SMALL or T_ERS_LARGE for an erase, chosen by the class of the target block.
- R9: When `vpp_ok` is low at the start of an operation, the operation fails with status bit 3 and bit 4 or bit 5 set, and the array is unchanged.
- R10: 0xB0 during an erase suspends it: `ready` goes high and status bit 6 is set. Reads and programs of other blocks then work. 0xD0 resumes the erase, and the busy cycles before and after the suspension add up to the full erase time.
- R11: A program aimed at the block whose erase is suspended is refused with status bit 4. The resumed erase still completes.
- R12: 0xB0 during a stand-alone program suspends it: `ready` goes high and status bit 2 is set. Reads are allowed. 0xD0 resumes the program, and the busy cycles add up to the full program time.
- R13: An erase setup followed by any byte other than 0xD0 sets status bits 4 and 5. 0x50 clears bits 1, 3, 4 and 5. 0x70 selects status reads, which appear in `rdata[7:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrdn_n | input | 1 | Low: deep power-down and abort |
| unlock_all | input | 1 | High-voltage override; unlocks all blocks |
| wp_n | input | 1 | Low: boot blocks locked |
| vpp_ok | input | 1 | Program supply above lockout |
| we_n | input | 1 | Write strobe, active low |
| addr | input | AW | Word address |
| wdata | input | 16 | Command or program data |
| rdata | output | 16 | Array word or status |
| ready | output | 1 | High when not busy |

## Verification
The bench goes after the suspend accounting, where a design that restarts or double-counts the erase timer would report a total busy time other than the full erase time. It targets the boundary between adjacent blocks, where a wrong block decode would erase the neighbouring word too. It targets a program aimed at the suspended block, which a design without the conflict check would apply. It also checks that a power-down in mid-erase leaves the array intact and comes back in read-array mode rather than status mode. Protection, supply lockout and sequence errors are each checked through both the status bits and the unchanged array word.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_PSET, S_ESET, S_PROG, S_ERASE,
    S_ESUS, S_ESUS_PSET, S_ESUS_PROG, S_PSUS
  } seq_st_e;

  localparam logic [7:0] CMD_READ = 8'hFF;
  localparam logic [7:0] CMD_STAT = 8'h70;
  localparam logic [7:0] CMD_CLR  = 8'h50;
  localparam logic [7:0] CMD_PSET = 8'h40;
  localparam logic [7:0] CMD_ESET = 8'h20;
  localparam logic [7:0] CMD_GO   = 8'hD0;
  localparam logic [7:0] CMD_HOLD = 8'hB0;

  localparam int NUM_BLK = 23;
  localparam int IW      = 5;
endpackage

// File: rtl/fseq_blkmap.sv
module fseq_blkmap
  import flash_seq_pkg::*;
#(
  parameter int SMALL_W  = 4,
  parameter int LARGE_W  = 8,
  parameter bit BOOT_TOP = 1'b0,
  parameter int AW       = 8
) (
  input  logic [AW-1:0] addr,
  output logic [IW-1:0] blk_idx,
  output logic [AW-1:0] blk_base,
  output logic          is_small,
  output logic          is_boot,
  output logic          in_range
);
  localparam int SMALL_REG = 8 * SMALL_W;
  localparam int MAIN_REG  = 15 * LARGE_W;
  localparam int TOTAL     = SMALL_REG + MAIN_REG;
  localparam int SB        = $clog2(SMALL_W);
  localparam int LB        = $clog2(LARGE_W);

  assign in_range = ({1'b0, addr} < (AW+1)'(TOTAL));
  assign blk_base = is_small ? (addr & ~AW'(SMALL_W - 1)) : (addr & ~AW'(LARGE_W - 1));

  generate
    if (BOOT_TOP == 1'b0) begin : g_bottom
      always_comb begin
        if (addr < AW'(SMALL_REG)) begin
          is_small = 1'b1;
          blk_idx  = IW'(addr >> SB);
          is_boot  = (blk_idx < IW'(2));
        end else begin
          is_small = 1'b0;
          is_boot  = 1'b0;
          blk_idx  = IW'(8) + IW'((addr - AW'(SMALL_REG)) >> LB);
        end
      end
    end else begin : g_top
      always_comb begin
        if (addr < AW'(MAIN_REG)) begin
          is_small = 1'b0;
          is_boot  = 1'b0;
          blk_idx  = IW'(addr >> LB);
        end else begin
          is_small = 1'b1;
          blk_idx  = IW'(15) + IW'((addr - AW'(MAIN_REG)) >> SB);
          is_boot  = (blk_idx >= IW'(21));
        end
      end
    end
  endgenerate
endmodule

// File: rtl/fseq_array.sv
module fseq_array #(
  parameter int DW      = 16,
  parameter int AW      = 8,
  parameter int DEPTH   = 152,
  parameter int SMALL_W = 4,
  parameter int LARGE_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          pgm_en,
  input  logic [AW-1:0] pgm_addr,
  input  logic [DW-1:0] pgm_data,
  input  logic          ers_en,
  input  logic [AW-1:0] ers_base,
  input  logic          ers_small
);
  logic [DW-1:0] mem [DEPTH];
  int            ers_size;

  assign ers_size = ers_small ? SMALL_W : LARGE_W;
  assign rd_data  = (int'(rd_addr) < DEPTH) ? mem[rd_addr] : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ers_en && (i >= int'(ers_base)) && (i < int'(ers_base) + ers_size))
          mem[i] <= '1;
        else if (pgm_en && (int'(pgm_addr) == i))
          mem[i] <= mem[i] & pgm_data;
      end
    end
  end

  AST_ONE_CELL_ACTION: assert property (@(posedge clk) disable iff (!rst_n) !(pgm_en && ers_en)); // R10
endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int AW     = 8,
  parameter int DW     = 16,
  parameter int T_PS   = 17,
  parameter int T_PL   = 8,
  parameter int T_ES   = 40,
  parameter int T_EL   = 60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwrdn_n,
  input  logic          unlock_all,
  input  logic          wp_n,
  input  logic          vpp_ok,
  input  logic          wr_stb,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  input  logic [IW-1:0] tgt_idx,
  input  logic [AW-1:0] tgt_base,
  input  logic          tgt_small,
  input  logic          tgt_boot,
  input  logic          tgt_ok,
  output logic          pgm_en,
  output logic [AW-1:0] pgm_addr,
  output logic [DW-1:0] pgm_data,
  output logic          ers_en,
  output logic [AW-1:0] ers_base,
  output logic          ers_small,
  output logic [7:0]    status,
  output logic          show_status,
  output logic          ready
);
  localparam int TMAX1 = (T_PS > T_PL) ? T_PS : T_PL;
  localparam int TMAX2 = (T_ES > T_EL) ? T_ES : T_EL;
  localparam int TMAX  = (TMAX1 > TMAX2) ? TMAX1 : TMAX2;
  localparam int TW    = $clog2(TMAX + 1);

  seq_st_e       st, st_n;
  logic [TW-1:0] tmr, tmr_n, esave, esave_n;
  logic [IW-1:0] eidx, eidx_n;
  logic [AW-1:0] ebase, ebase_n, paddr, paddr_n;
  logic [DW-1:0] pdata, pdata_n;
  logic          esmall, esmall_n;
  logic          e_err, e_err_n, p_err, p_err_n, v_err, v_err_n, l_err, l_err_n;
  logic          rd_stat, rd_stat_n;
  logic [7:0]    cmd;
  logic          locked;
  logic          esus_flag, psus_flag;

  assign cmd       = cmd_data[7:0];
  assign locked    = !tgt_ok || (tgt_boot && !wp_n && !unlock_all);
  assign ready     = !((st == S_PROG) || (st == S_ERASE) || (st == S_ESUS_PROG));
  assign esus_flag = (st == S_ESUS) || (st == S_ESUS_PSET) || (st == S_ESUS_PROG);
  assign psus_flag = (st == S_PSUS);
  assign status    = {ready, esus_flag, e_err, p_err, v_err, psus_flag, l_err, 1'b0};
  assign show_status = rd_stat;
  assign pgm_addr  = paddr;
  assign pgm_data  = pdata;
  assign ers_base  = ebase;
  assign ers_small = esmall;

  always_comb begin
    st_n = st;  tmr_n = tmr;  esave_n = esave;
    eidx_n = eidx;  ebase_n = ebase;  esmall_n = esmall;
    paddr_n = paddr;  pdata_n = pdata;
    e_err_n = e_err;  p_err_n = p_err;  v_err_n = v_err;  l_err_n = l_err;
    rd_stat_n = rd_stat;
    pgm_en = 1'b0;
    ers_en = 1'b0;
    if (!pwrdn_n) begin
      st_n = S_IDLE;
      e_err_n = 1'b0;  p_err_n = 1'b0;  v_err_n = 1'b0;  l_err_n = 1'b0;
      rd_stat_n = 1'b0;
    end else begin
      unique case (st)
        S_IDLE, S_ESUS, S_PSUS: begin
          if (wr_stb) begin
            case (cmd)
              CMD_READ: rd_stat_n = 1'b0;
              CMD_STAT: rd_stat_n = 1'b1;
              CMD_CLR: begin
                e_err_n = 1'b0;  p_err_n = 1'b0;  v_err_n = 1'b0;  l_err_n = 1'b0;
              end
              CMD_PSET: begin
                if (st != S_PSUS) begin
                  st_n      = (st == S_IDLE) ? S_PSET : S_ESUS_PSET;
                  rd_stat_n = 1'b1;
                end
              end
              CMD_ESET: begin
                if (st == S_IDLE) begin
                  st_n      = S_ESET;
                  rd_stat_n = 1'b1;
                end
              end
              CMD_GO: begin
                if (st == S_ESUS) begin
                  st_n      = S_ERASE;
                  tmr_n     = esave;
                  rd_stat_n = 1'b1;
                end else if (st == S_PSUS) begin
                  st_n      = S_PROG;
                  rd_stat_n = 1'b1;
                end
              end
              default: ;
            endcase
          end
        end
        S_PSET, S_ESUS_PSET: begin
          if (wr_stb) begin
            rd_stat_n = 1'b1;
            if (!vpp_ok) begin
              v_err_n = 1'b1;  p_err_n = 1'b1;
              st_n = (st == S_PSET) ? S_IDLE : S_ESUS;
            end else if (locked) begin
              l_err_n = 1'b1;  p_err_n = 1'b1;
              st_n = (st == S_PSET) ? S_IDLE : S_ESUS;
            end else if ((st == S_ESUS_PSET) && (tgt_idx == eidx)) begin
              p_err_n = 1'b1;
              st_n    = S_ESUS;
            end else begin
              paddr_n = cmd_addr;
              pdata_n = cmd_data;
              tmr_n   = tgt_small ? TW'(T_PS) : TW'(T_PL);
              st_n    = (st == S_PSET) ? S_PROG : S_ESUS_PROG;
            end
          end
        end
        S_ESET: begin
          if (wr_stb) begin
            rd_stat_n = 1'b1;
            st_n      = S_IDLE;
            if (cmd != CMD_GO) begin
              e_err_n = 1'b1;  p_err_n = 1'b1;
            end else if (!vpp_ok) begin
              v_err_n = 1'b1;  e_err_n = 1'b1;
            end else if (locked) begin
              l_err_n = 1'b1;  e_err_n = 1'b1;
            end else begin
              eidx_n   = tgt_idx;
              ebase_n  = tgt_base;
              esmall_n = tgt_small;
              tmr_n    = tgt_small ? TW'(T_ES) : TW'(T_EL);
              st_n     = S_ERASE;
            end
          end
        end
        S_PROG, S_ESUS_PROG: begin
          if (tmr == TW'(1)) begin
            pgm_en = 1'b1;
            st_n   = (st == S_PROG) ? S_IDLE : S_ESUS;
          end else begin
            tmr_n = tmr - TW'(1);
            if ((st == S_PROG) && wr_stb && (cmd == CMD_HOLD)) st_n = S_PSUS;
          end
        end
        S_ERASE: begin
          if (tmr == TW'(1)) begin
            ers_en = 1'b1;
            st_n   = S_IDLE;
          end else begin
            tmr_n = tmr - TW'(1);
            if (wr_stb && (cmd == CMD_HOLD)) begin
              st_n    = S_ESUS;
              esave_n = tmr - TW'(1);
            end
          end
        end
        default: st_n = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  tmr <= '0;  esave <= '0;
      eidx <= '0;  ebase <= '0;  esmall <= 1'b0;
      paddr <= '0;  pdata <= '0;
      e_err <= 1'b0;  p_err <= 1'b0;  v_err <= 1'b0;  l_err <= 1'b0;
      rd_stat <= 1'b0;
    end else begin
      st <= st_n;  tmr <= tmr_n;  esave <= esave_n;
      eidx <= eidx_n;  ebase <= ebase_n;  esmall <= esmall_n;
      paddr <= paddr_n;  pdata <= pdata_n;
      e_err <= e_err_n;  p_err <= p_err_n;  v_err <= v_err_n;  l_err <= l_err_n;
      rd_stat <= rd_stat_n;
    end
  end

  AST_PWRDN_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrdn_n |=> (ready && (st == S_IDLE))); // R6
  AST_BOOT_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_PSET) && wr_stb && pwrdn_n && vpp_ok && tgt_boot && !wp_n && !unlock_all) |=> (st != S_PROG)); // R4
  AST_LOCKOUT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (((st == S_PSET) || (st == S_ESUS_PSET)) && wr_stb && pwrdn_n && !vpp_ok) |=> status[3]); // R9
  AST_ERASE_COUNT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ESUS_PROG) |=> $stable(esave)); // R10
  AST_BUSY_TIMER_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (tmr != '0)); // R8
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int DW           = 16,
  parameter int SMALL_W      = 4,
  parameter int LARGE_W      = 8,
  parameter bit BOOT_TOP     = 1'b0,
  parameter int T_PROG_SMALL = 17,
  parameter int T_PROG_LARGE = 8,
  parameter int T_ERS_SMALL  = 40,
  parameter int T_ERS_LARGE  = 60,
  parameter int AW           = $clog2(8 * SMALL_W + 15 * LARGE_W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwrdn_n,
  input  logic          unlock_all,
  input  logic          wp_n,
  input  logic          vpp_ok,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          ready
);
  localparam int DEPTH = 8 * SMALL_W + 15 * LARGE_W;

  logic [1:0]    rst_sync;
  logic          srst_n;
  logic          we_q;
  logic          wr_stb;
  logic [IW-1:0] tgt_idx;
  logic [AW-1:0] tgt_base;
  logic          tgt_small, tgt_boot, tgt_ok;
  logic          pgm_en, ers_en, ers_small;
  logic [AW-1:0] pgm_addr, ers_base;
  logic [DW-1:0] pgm_data, arr_data;
  logic [7:0]    status;
  logic          show_status, core_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) we_q <= 1'b1;
    else         we_q <= we_n;
  end
  assign wr_stb = we_n && !we_q;

  fseq_blkmap #(.SMALL_W(SMALL_W), .LARGE_W(LARGE_W), .BOOT_TOP(BOOT_TOP), .AW(AW)) u_map (
    .addr(addr), .blk_idx(tgt_idx), .blk_base(tgt_base),
    .is_small(tgt_small), .is_boot(tgt_boot), .in_range(tgt_ok)
  );

  fseq_ctrl #(.AW(AW), .DW(DW), .T_PS(T_PROG_SMALL), .T_PL(T_PROG_LARGE),
              .T_ES(T_ERS_SMALL), .T_EL(T_ERS_LARGE)) u_ctrl (
    .clk(clk), .rst_n(srst_n), .pwrdn_n(pwrdn_n), .unlock_all(unlock_all),
    .wp_n(wp_n), .vpp_ok(vpp_ok), .wr_stb(wr_stb), .cmd_addr(addr), .cmd_data(wdata),
    .tgt_idx(tgt_idx), .tgt_base(tgt_base), .tgt_small(tgt_small),
    .tgt_boot(tgt_boot), .tgt_ok(tgt_ok),
    .pgm_en(pgm_en), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
    .ers_en(ers_en), .ers_base(ers_base), .ers_small(ers_small),
    .status(status), .show_status(show_status), .ready(core_ready)
  );

  fseq_array #(.DW(DW), .AW(AW), .DEPTH(DEPTH), .SMALL_W(SMALL_W), .LARGE_W(LARGE_W)) u_arr (
    .clk(clk), .rst_n(srst_n), .rd_addr(addr), .rd_data(arr_data),
    .pgm_en(pgm_en), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
    .ers_en(ers_en), .ers_base(ers_base), .ers_small(ers_small)
  );

  assign ready = core_ready || !pwrdn_n;
  always_comb begin
    if (!pwrdn_n)         rdata = '0;
    else if (show_status) rdata = {(DW-8)'(0), status};
    else                  rdata = arr_data;
  end

  AST_NO_CELL_CHANGE_IN_PD: assert property (@(posedge clk) disable iff (!srst_n)
    !pwrdn_n |-> !(pgm_en || ers_en)); // R6
  AST_CELL_CHANGE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!srst_n)
    (pgm_en || ers_en) |-> !core_ready); // R7
endmodule

// File: tb/flash_seq_test.sv
module flash_seq_test;
  localparam int AW = 8;
  localparam int K_DATA  = 0;
  localparam int K_READY = 1;
  localparam int K_BUSY  = 2;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    int          base;
    string       tag;
  } sb_item_t;

  logic          clk = 1'b0;
  logic          rst_n, pwrdn_n, unlock_all, wp_n, vpp_ok, we_n;
  logic [AW-1:0] addr;
  logic [15:0]   wdata, rdata;
  logic          ready;

  int       errors = 0;
  int       checks = 0;
  int       busy_total = 0;
  int       cyc = 0;
  sb_item_t sbq[$];
  event     sb_ev;

  flash_seq uut (
    .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .unlock_all(unlock_all),
    .wp_n(wp_n), .vpp_ok(vpp_ok), .we_n(we_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ready(ready)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!ready) busy_total <= busy_total + 1;
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  // monitor: pops expected items and compares with what the design shows
  initial begin
    sb_item_t it;
    logic [31:0] act;
    forever begin
      @(sb_ev);
      while (sbq.size() > 0) begin
        it = sbq.pop_front();
        case (it.kind)
          K_DATA:  act = {16'h0, rdata};
          K_READY: act = {31'h0, ready};
          default: act = busy_total - it.base;
        endcase
        checks = checks + 1;
        if (act !== it.exp) begin
          errors = errors + 1;
          $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expect_item(input int kind, input logic [31:0] exp, input int base, input string tag);
    sb_item_t it;
    it.kind = kind; it.exp = exp; it.base = base; it.tag = tag;
    sbq.push_back(it);
    #2;
    ->sb_ev;
    @(negedge clk);
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [15:0] d);
    bus_wr(a, 16'h0040);
    bus_wr(a, d);
  endtask

  task automatic erase(input logic [AW-1:0] a);
    bus_wr(a, 16'h0020);
    bus_wr(a, 16'h00D0);
  endtask

  task automatic wait_ready();
    while (!ready) @(negedge clk);
  endtask

  task automatic arr_chk(input logic [AW-1:0] a, input logic [15:0] exp, input string tag);
    bus_wr(a, 16'h00FF);
    addr = a;
    expect_item(K_DATA, {16'h0, exp}, 0, tag);
  endtask

  task automatic stat_chk(input logic [7:0] exp, input string tag);
    bus_wr('0, 16'h0070);
    expect_item(K_DATA, {24'h0, exp}, 0, tag);
  endtask

  initial begin
    int base;
    int pre;
    rst_n = 1'b0; pwrdn_n = 1'b1; unlock_all = 1'b0; wp_n = 1'b1; vpp_ok = 1'b1;
    we_n = 1'b1; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    expect_item(K_READY, 1, 0, "R7 ready after reset");
    addr = 8'd5;
    expect_item(K_DATA, 16'hFFFF, 0, "R2 erased array in read mode after reset");
    stat_chk(8'h80, "R7 idle status");

    // program, small block timing
    base = busy_total;
    prog(8'd10, 16'h1234);
    expect_item(K_READY, 0, 0, "R7 busy during program");
    wait_ready();
    expect_item(K_BUSY, 17, base, "R8 small-block program time");
    arr_chk(8'd10, 16'h1234, "R2 programmed word");
    prog(8'd10, 16'h0FF0); wait_ready();
    arr_chk(8'd10, 16'h0230, "R2 program ANDs bits");

    // large block timing
    base = busy_total;
    prog(8'd40, 16'hA5A5); wait_ready();
    expect_item(K_BUSY, 8, base, "R8 large-block program time");
    stat_chk(8'h80, "R7 status after program");

    // R3 address taken at strobe rise
    bus_wr(8'd12, 16'h0040);
    @(negedge clk); addr = 8'd12; wdata = 16'h0000; we_n = 1'b0;
    @(negedge clk); addr = 8'd13;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk);
    wait_ready();
    arr_chk(8'd13, 16'h0000, "R3 late address used");
    arr_chk(8'd12, 16'hFFFF, "R3 early address ignored");

    // R4 boot lock
    wp_n = 1'b0;
    prog(8'd2, 16'h0000); wait_ready();
    stat_chk(8'h92, "R4 boot program refused status");
    arr_chk(8'd2, 16'hFFFF, "R4 boot word unchanged");
    bus_wr('0, 16'h0050);
    stat_chk(8'h80, "R13 clear status");
    prog(8'd20, 16'h00AA); wait_ready();
    arr_chk(8'd20, 16'h00AA, "R4 parameter block never locked");
    erase(8'd1); wait_ready();
    stat_chk(8'hA2, "R4 boot erase refused status");
    bus_wr('0, 16'h0050);

    // R5 override
    unlock_all = 1'b1;
    prog(8'd2, 16'h00FF); wait_ready();
    arr_chk(8'd2, 16'h00FF, "R5 override unlocks boot block");
    unlock_all = 1'b0; wp_n = 1'b1;

    // R9 supply lockout
    vpp_ok = 1'b0;
    prog(8'd41, 16'h0000); wait_ready();
    stat_chk(8'h98, "R9 lockout status");
    arr_chk(8'd41, 16'hFFFF, "R9 word unchanged");
    bus_wr('0, 16'h0050);
    vpp_ok = 1'b1;

    // R1 block erase extents
    base = busy_total;
    erase(8'd9); wait_ready();
    expect_item(K_BUSY, 40, base, "R8 small-block erase time");
    arr_chk(8'd10, 16'hFFFF, "R1 word in erased parameter block");
    arr_chk(8'd13, 16'h0000, "R1 neighbour block kept");
    prog(8'd33, 16'h1111); wait_ready();
    base = busy_total;
    erase(8'd38); wait_ready();
    expect_item(K_BUSY, 60, base, "R8 large-block erase time");
    arr_chk(8'd33, 16'hFFFF, "R1 main block erased");
    arr_chk(8'd40, 16'hA5A5, "R1 next main block kept");

    // R10 / R11 erase suspend
    prog(8'd48, 16'hF0F0); wait_ready();
    base = busy_total;
    erase(8'd48);
    repeat (10) @(negedge clk);
    bus_wr(8'd48, 16'h00B0);
    expect_item(K_READY, 1, 0, "R10 ready high when erase suspended");
    pre = busy_total - base;
    stat_chk(8'hC0, "R10 erase-suspended status");
    arr_chk(8'd40, 16'hA5A5, "R10 read other block in suspend");
    base = busy_total;
    prog(8'd56, 16'h5555); wait_ready();
    expect_item(K_BUSY, 8, base, "R10 program inside erase suspend");
    stat_chk(8'hC0, "R10 back in erase suspend");
    arr_chk(8'd56, 16'h5555, "R10 program to other block");
    prog(8'd48, 16'h0000); wait_ready();
    stat_chk(8'hD0, "R11 program to suspended block refused");
    arr_chk(8'd48, 16'hF0F0, "R11 word untouched");
    bus_wr('0, 16'h0050);
    base = busy_total;
    bus_wr(8'd48, 16'h00D0);
    wait_ready();
    expect_item(K_BUSY, 60, base - pre, "R10 erase total time across suspend");
    arr_chk(8'd48, 16'hFFFF, "R11 resumed erase completes");

    // R12 program suspend
    base = busy_total;
    prog(8'd60, 16'h0000);
    bus_wr(8'd60, 16'h00B0);
    expect_item(K_READY, 1, 0, "R12 ready high when program suspended");
    stat_chk(8'h84, "R12 program-suspended status");
    arr_chk(8'd40, 16'hA5A5, "R12 read during program suspend");
    bus_wr(8'd60, 16'h00D0);
    wait_ready();
    expect_item(K_BUSY, 8, base, "R12 program total time across suspend");
    arr_chk(8'd60, 16'h0000, "R12 resumed program completes");

    // R13 sequence error
    bus_wr(8'd70, 16'h0020);
    bus_wr(8'd70, 16'h00FF);
    stat_chk(8'hB0, "R13 erase setup without confirm");
    bus_wr('0, 16'h0050);
    stat_chk(8'h80, "R13 errors cleared");

    // R6 power-down
    prog(8'd64, 16'h0000); wait_ready();
    erase(8'd64);
    repeat (5) @(negedge clk);
    pwrdn_n = 1'b0;
    #2;
    expect_item(K_READY, 1, 0, "R6 ready high in power-down");
    expect_item(K_DATA, 16'h0000, 0, "R6 rdata zero in power-down");
    prog(8'd70, 16'h0000);
    repeat (3) @(negedge clk);
    pwrdn_n = 1'b1;
    @(negedge clk);
    addr = 8'd64;
    expect_item(K_DATA, 16'h0000, 0, "R6 aborted erase left array, read mode after exit");
    addr = 8'd70;
    expect_item(K_DATA, 16'hFFFF, 0, "R6 write ignored in power-down");
    stat_chk(8'h80, "R6 status clean after power-down");

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule